// File: doc/BRIEF.md
# Held-Buffer Serial Receiver with Parity Check

This block receives asynchronous serial characters on a single line that idles high. A high-to-low transition on the line, after a two-stage synchronizer, produces a one-cycle start pulse. The controller then waits half a bit period and checks that the line is still low, which rejects short glitches. It then samples the data bits, least significant first, followed by one parity bit, each one bit period apart, into a shift register. A completed character is copied into a buffer register in one state, and the next state raises `buf_full`.

The consumer reads `rx_word`, a 16-bit zero-extended copy of the data. It then pulses `read_strobe` to release the buffer. Until that pulse, further characters on the line are ignored. A registered parity flag, `par_err`, loads while the buffer is full. It keeps its value until a reset or until the next character completes.

The parameters are the data width, the parity sense and the bit period in clocks.

Top module: `serial_rx_holdbuf`

## Requirements
- R1: While `rst_n` is low, and after it is released until a character completes, `buf_full`, `par_err` and `rx_word` are all zero.
- R2: A character begins only on a falling edge of `rx_line`. If the line is back high at the half-bit check, the attempt is dropped and nothing is buffered.
- R3: Data bits arrive least significant first, followed by one parity bit. `rx_word[DATA_W-1:0]` holds the data and `rx_word[15:DATA_W]` is always zero.
- R4: `buf_full` rises after a complete character and stays high until `read_strobe` is seen; it falls one cycle after that strobe.
- R5: With `ODD_PARITY`=0, `par_err` is 1 when the XOR of the data bits and the parity bit is 1. With `ODD_PARITY`=1, `par_err` is 1 when that XOR is 0.
- R6: `par_err` changes only while `buf_full` is high. Once set, it stays set through a read, until a reset or the completion of the next character.
- R7: While `buf_full` is high, frames on `rx_line` are ignored. `rx_word` and `par_err` stay unchanged.
- R8: A `read_strobe` while `buf_full` is low has no effect. A frame that follows it is received normally.
- R9: After a read, the next frame on the line is received and replaces `rx_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Serial input, idle high |
| read_strobe | input | 1 | Consumer releases the buffer |
| rx_word | output | 16 | Received data, zero-extended |
| buf_full | output | 1 | Buffer holds an unread character |
| par_err | output | 1 | Parity error of the buffered character |

## Verification
The hardest case to reach from the ports is a complete frame arriving while the buffer is still full. The bench holds back `read_strobe` after a good character and sends a second frame with different data and bad parity. It then checks that neither `rx_word` nor `par_err` moved. A read is then issued and a third frame confirms that reception resumes. The glitch case is driven with a low pulse shorter than half a bit, so the start check sees the line high again.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONFIRM,
    ST_SHIFT,
    ST_XFER,
    ST_FULL
  } rx_state_t;
endpackage

// File: rtl/rxs_reset_sync.sv
module rxs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_sync_n = chain_q[1];
endmodule

// File: rtl/rxs_line_sync.sv
module rxs_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q,
  output logic fall_pulse
);
  logic meta_q, stab_q, prev_q;

  // idle level is 1, so reset loads ones to avoid a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_in;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign line_q     = stab_q;
  assign fall_pulse = prev_q & ~stab_q;
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl #(
  parameter int DATA_W   = 8,
  parameter int BIT_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_q,
  input  logic              fall_pulse,
  input  logic              read_strobe,
  output logic [DATA_W:0]   frame_sr,
  output logic              load_buf,
  output logic              full
);
  import rxs_pkg::*;

  localparam int CNT_W = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam int HALF  = BIT_CLKS / 2;
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BIT_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W);

  rx_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DATA_W:0]  sr_q;
  logic             shift_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    shift_en = 1'b0;
    load_buf = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall_pulse) begin
          state_d = ST_CONFIRM;
          cnt_d   = '0;
        end
      end
      ST_CONFIRM: begin
        if (cnt_q == CNT_HALF) begin
          cnt_d   = '0;
          idx_d   = '0;
          state_d = line_q ? ST_IDLE : ST_SHIFT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (cnt_q == CNT_FULL) begin
          cnt_d    = '0;
          shift_en = 1'b1;
          idx_d    = idx_q + 1'b1;
          if (idx_q == IDX_LAST) state_d = ST_XFER;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_XFER: begin
        load_buf = 1'b1;
        state_d  = ST_FULL;
      end
      ST_FULL: begin
        if (read_strobe) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  // shift right: the first bit received ends in bit 0, the parity bit in the top bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {line_q, sr_q[DATA_W:1]};
  end

  assign frame_sr = sr_q;
  assign full     = (state_q == ST_FULL);
endmodule

// File: rtl/serial_rx_holdbuf.sv
module serial_rx_holdbuf #(
  parameter int DATA_W     = 8,
  parameter bit ODD_PARITY = 1'b0,
  parameter int BIT_CLKS   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_line,
  input  logic        read_strobe,
  output logic [15:0] rx_word,
  output logic        buf_full,
  output logic        par_err
);
  localparam int PAD_W = 16 - DATA_W;

  logic              rst_sync_n;
  logic              line_q, fall_pulse, load_buf, full;
  logic [DATA_W:0]   frame_sr;
  logic [DATA_W:0]   br_q;
  logic              par_err_q;

  rxs_reset_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rxs_line_sync u_sync (
    .clk(clk), .rst_n(rst_sync_n), .line_in(rx_line),
    .line_q(line_q), .fall_pulse(fall_pulse)
  );

  rxs_ctrl #(.DATA_W(DATA_W), .BIT_CLKS(BIT_CLKS)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .line_q(line_q), .fall_pulse(fall_pulse),
    .read_strobe(read_strobe), .frame_sr(frame_sr), .load_buf(load_buf), .full(full)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   br_q <= '0;
    else if (load_buf) br_q <= frame_sr;
  end

  // parity flop loads only while the buffer is marked full
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) par_err_q <= 1'b0;
    else if (full)   par_err_q <= (^br_q) ^ ODD_PARITY;
  end

  assign rx_word  = {{PAD_W{1'b0}}, br_q[DATA_W-1:0]};
  assign buf_full = full;
  assign par_err  = par_err_q;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int DATA_W = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        read_strobe,
  input logic [15:0] rx_word,
  input logic        buf_full,
  input logic        par_err
);
  // R4
  full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $past(read_strobe));

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && $past(buf_full)) |-> $stable(rx_word));

  // R6
  par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(par_err) |-> $past(buf_full));

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word[15:DATA_W] == '0);
endmodule

bind serial_rx_holdbuf rxs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .read_strobe(read_strobe),
  .rx_word(rx_word), .buf_full(buf_full), .par_err(par_err)
);

// File: tb/test_serial_rx_holdbuf.sv
`timescale 1ns/1ps
module test_serial_rx_holdbuf;
  localparam int DW  = 8;
  localparam int BIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_a = 1'b1, line_b = 1'b1;
  logic rd_a = 1'b0, rd_b = 1'b0;
  logic [15:0] word_a, word_b;
  logic full_a, full_b, perr_a, perr_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_rx_holdbuf #(.DATA_W(DW), .ODD_PARITY(1'b0), .BIT_CLKS(BIT)) i_serial_rx_holdbuf (
    .clk(clk), .rst_n(rst_n), .rx_line(line_a), .read_strobe(rd_a),
    .rx_word(word_a), .buf_full(full_a), .par_err(perr_a));

  serial_rx_holdbuf #(.DATA_W(DW), .ODD_PARITY(1'b1), .BIT_CLKS(BIT)) i_serial_rx_holdbuf_odd (
    .clk(clk), .rst_n(rst_n), .rx_line(line_b), .read_strobe(rd_b),
    .rx_word(word_b), .buf_full(full_b), .par_err(perr_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit sel, input logic v);
    if (sel) line_b = v; else line_a = v;
  endtask

  // one frame: start, data LSB first, parity, stop, short idle
  task automatic send(input bit sel, input logic [DW-1:0] d, input logic pbit);
    @(negedge clk); drive(sel, 1'b0);
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < DW; i++) begin
      drive(sel, d[i]);
      repeat (BIT) @(negedge clk);
    end
    drive(sel, pbit);
    repeat (BIT) @(negedge clk);
    drive(sel, 1'b1);
    repeat (BIT + 6) @(negedge clk);
  endtask

  task automatic read_a();
    @(negedge clk); rd_a = 1'b1;
    @(negedge clk); rd_a = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 buf_full", full_a, 0);
    chk("R1 par_err", perr_a, 0);
    chk("R1 rx_word", word_a, 0);
  endtask

  task automatic t_good();
    send(0, 8'hA5, ^8'hA5);
    chk("R3 data", word_a, 16'h00A5);
    chk("R4 buf_full set", full_a, 1);
    chk("R5 even ok", perr_a, 0);
    read_a();
    chk("R4 buf_full cleared", full_a, 0);
  endtask

  task automatic t_bad_sticky();
    send(0, 8'h3C, ~(^8'h3C));
    chk("R5 even error", perr_a, 1);
    chk("R3 data", word_a, 16'h003C);
    read_a();
    chk("R6 sticky after read", perr_a, 1);
    send(0, 8'h81, ^8'h81);
    chk("R6 cleared by next char", perr_a, 0);
    chk("R9 next data", word_a, 16'h0081);
  endtask

  task automatic t_ignore_full();
    // buffer still holds 0x81 from the previous task
    send(0, 8'h5E, ~(^8'h5E));
    chk("R7 word held", word_a, 16'h0081);
    chk("R7 par_err held", perr_a, 0);
    chk("R7 still full", full_a, 1);
    read_a();
    send(0, 8'hC3, ^8'hC3);
    chk("R9 resume", word_a, 16'h00C3);
    read_a();
  endtask

  task automatic t_glitch();
    @(negedge clk); line_a = 1'b0;
    repeat (3) @(negedge clk);
    line_a = 1'b1;
    repeat (BIT * 12) @(negedge clk);
    chk("R2 glitch dropped", full_a, 0);
    chk("R2 word unchanged", word_a, 16'h00C3);
  endtask

  task automatic t_stray_read();
    read_a();
    chk("R8 stray read", full_a, 0);
    send(0, 8'hFF, ^8'hFF);
    chk("R8 frame after stray read", word_a, 16'h00FF);
    chk("R3 upper zero", word_a[15:8], 0);
  endtask

  task automatic t_odd();
    send(1, 8'h07, ^8'h07);
    chk("R5 odd error", perr_b, 1);
    @(negedge clk); rd_b = 1'b1; @(negedge clk); rd_b = 1'b0; @(negedge clk);
    send(1, 8'h07, ~(^8'h07));
    chk("R5 odd ok", perr_b, 0);
    chk("R3 odd data", word_b, 16'h0007);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears full", full_a, 0);
    chk("R1 reset clears word", word_a, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_good();
    t_bad_sticky();
    t_ignore_full();
    t_glitch();
    t_stray_read();
    t_odd();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule